// File: doc/BRIEF.md
# Framed Serial Register Port

This block is the slave end of a 16-bit serial link. An external controller frames each transfer by pulling an active-low frame-sync line low. It then toggles a serial clock, while the block shifts a command word in on its data input and a result word out on its data output. Everything runs on a fast system clock. The serial clock, the frame-sync line and the input data each pass through a synchronizer, and the serial clock and frame sync are then edge-detected. The block therefore needs no second clock domain.

The first output bit has a special rule. If the serial clock is low at the moment frame sync falls, the frame-sync edge itself puts bit 15 of the result word on the output. If the serial clock is high at that moment (its idle level), the first serial-clock falling edge puts bit 15 out. After that, output bits change on falling edges and input bits are sampled on rising edges.

A word counts as received only when all 16 bits arrive inside one frame. The block then raises a one-cycle strobe carrying the word to the register decoder. Raising frame sync at any time clears the shift logic, which lets the controller recover a lost interface. A small test register is written by words whose top two bits are 01. Writing 0x4002 puts it back to its default value, 0x0002.

Top module: `ssp_frame_port`

## Requirements
- R1: After reset, sdo_out is 0, wr_valid is 0 and test_reg holds its default 0x0002.
- R2: Input bits are sampled on serial-clock rising edges, MSB first. After the 16th rising edge in a frame, wr_valid is high for exactly one system-clock cycle, and wr_word then carries the 16 bits with the first bit at bit 15.
- R3: If the serial clock is low when frame sync falls, sdo_out shows tx_word[15] before any serial-clock edge.
- R4: If the serial clock is high when frame sync falls, sdo_out stays 0 until the first serial-clock falling edge, and that edge presents tx_word[15].
- R5: Each later serial-clock falling edge presents the next lower bit of tx_word, so the 16 bits seen at the rising edges are tx_word[15] down to tx_word[0].
- R6: Raising frame sync before 16 bits have arrived discards the partial word with no wr_valid. The first bit of the next frame becomes bit 15 of a new word.
- R7: Serial-clock edges after the 16th bit in the same frame are ignored: there is no second wr_valid, and wr_word keeps the first 16 bits.
- R8: A received word whose bits 15:14 are 01 loads its bits 13:0 into test_reg. A word with any other code in bits 15:14 leaves test_reg unchanged.
- R9: Receiving 0x4002 restores test_reg to 0x0002, whatever it held before.
- R10: While frame sync is high, sdo_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the controller, idles high |
| fs_n_in | input | 1 | Active-low frame sync; high resets the interface |
| sdi_in | input | 1 | Serial data in |
| sdo_out | output | 1 | Serial data out |
| tx_word | input | 16 | Result word sent in the next frame |
| wr_valid | output | 1 | One-cycle strobe for a complete received word |
| wr_word | output | 16 | Received word for register decode |
| test_reg | output | 14 | Test register contents |

## Verification
The bench builds the block with its defaults: 16-bit words, a 2-bit register code and two synchronizer stages. It drives a serial-clock half period of eight system clocks, which keeps each serial edge well clear of the three-cycle synchronize-and-detect latency.

Both starting levels of the serial clock are used, so both ways of launching the first output bit are checked. Frames are cut short at nine bits and stretched to twenty bits to check the discard and ignore rules. Random words often carry code 01, so the test register is written, overwritten and restored many times.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Edge and level events seen by the shift logic, all in the system-clock domain
  typedef struct packed {
    logic sclk_rise;
    logic sclk_fall;
    logic sclk_lvl;
    logic fs_fall;
    logic fs_high;
    logic sdi;
  } ssp_evt_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int          N       = 1,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ssp_frontend.sv
module ssp_frontend
  import ssp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_in,
  input  logic     fs_n_in,
  input  logic     sdi_in,
  output ssp_evt_t evt
);
  logic [2:0] raw, synced;
  logic       sclk_prev, fs_prev;

  assign raw = {sclk_in, fs_n_in, sdi_in};

  // Serial clock and frame sync reset to their idle-high levels
  ssp_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      fs_prev   <= 1'b1;
    end else begin
      sclk_prev <= synced[2];
      fs_prev   <= synced[1];
    end
  end

  always_comb begin
    evt.sclk_lvl  = synced[2];
    evt.sclk_rise = synced[2] & ~sclk_prev;
    evt.sclk_fall = ~synced[2] & sclk_prev;
    evt.fs_high   = synced[1];
    evt.fs_fall   = ~synced[1] & fs_prev;
    evt.sdi       = synced[0];
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import ssp_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssp_evt_t          evt,
  input  logic [WORD_W-1:0] tx_word,
  output logic              sdo,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_word
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bitcnt, bitcnt_n;
  logic [WORD_W-1:0] rx_sr, rx_n, tx_sr, tx_n;
  logic              launched, launched_n, wr_n;
  logic              rx_en, tx_en;

  always_comb begin
    bitcnt_n   = bitcnt;
    rx_n       = rx_sr;
    tx_n       = tx_sr;
    launched_n = launched;
    rx_en      = 1'b0;
    tx_en      = 1'b0;
    wr_n       = 1'b0;
    if (evt.fs_high) begin
      bitcnt_n   = '0;
      rx_n       = '0;
      tx_n       = '0;
      launched_n = 1'b0;
      rx_en      = 1'b1;
      tx_en      = 1'b1;
    end else begin
      if (evt.fs_fall && !evt.sclk_lvl) begin
        tx_n       = tx_word;
        launched_n = 1'b1;
        tx_en      = 1'b1;
      end else if (evt.sclk_fall) begin
        tx_en      = 1'b1;
        launched_n = 1'b1;
        tx_n       = launched ? {tx_sr[WORD_W-2:0], 1'b0} : tx_word;
      end
      if (evt.sclk_rise && bitcnt < FULL) begin
        rx_en    = 1'b1;
        rx_n     = {rx_sr[WORD_W-2:0], evt.sdi};
        bitcnt_n = bitcnt + CNT_W'(1);
        wr_n     = (bitcnt == LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      launched <= 1'b0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= wr_n;
      if (rx_en) begin
        bitcnt <= bitcnt_n;
        rx_sr  <= rx_n;
      end
      if (tx_en) begin
        tx_sr    <= tx_n;
        launched <= launched_n;
      end
    end
  end

  assign sdo     = tx_sr[WORD_W-1];
  assign wr_word = rx_sr;

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R7
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= FULL);
  // R5
  tx_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_sr) |-> $past(evt.fs_high || evt.fs_fall || evt.sclk_fall));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt.fs_high) |-> !sdo);
endmodule

// File: rtl/ssp_test_reg.sv
module ssp_test_reg #(
  parameter int                      WORD_W    = 16,
  parameter int                      ADDR_W    = 2,
  parameter logic [ADDR_W-1:0]       SEL_CODE  = 2'b01,
  parameter logic [WORD_W-ADDR_W-1:0] DEF_VALUE = 14'h0002,
  localparam int DATA_W = WORD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  output logic [DATA_W-1:0] value
);
  logic hit;
  assign hit = wr_valid && (wr_word[WORD_W-1 -: ADDR_W] == SEL_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= DEF_VALUE;
    else if (hit) value <= wr_word[DATA_W-1:0];
  end

  // R8
  test_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(value) |-> $past(wr_valid));
endmodule

// File: rtl/ssp_frame_port.sv
module ssp_frame_port
  import ssp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = WORD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              fs_n_in,
  input  logic              sdi_in,
  output logic              sdo_out,
  input  logic [WORD_W-1:0] tx_word,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_word,
  output logic [DATA_W-1:0] test_reg
);
  logic [1:0] rst_q;
  logic       rst_int_n;
  ssp_evt_t   evt;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  ssp_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_int_n), .sclk_in(sclk_in), .fs_n_in(fs_n_in),
    .sdi_in(sdi_in), .evt(evt)
  );

  ssp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .evt(evt), .tx_word(tx_word),
    .sdo(sdo_out), .wr_valid(wr_valid), .wr_word(wr_word)
  );

  ssp_test_reg #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .SEL_CODE(ADDR_W'(1)), .DEF_VALUE(DATA_W'(2))
  ) u_treg (
    .clk(clk), .rst_n(rst_int_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .value(test_reg)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!wr_valid && !sdo_out));
endmodule

// File: tb/sim_ssp_frame_port.sv
module sim_ssp_frame_port;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n, sclk, fsn, sdi, sdo, wr_valid;
  logic [15:0] tx_word, wr_word;
  logic [13:0] test_reg;

  int          n_chk = 0, n_fail = 0, pulses = 0;
  logic [15:0] got_word = '0;
  logic [13:0] model_treg;
  bit          done = 0;

  always #4 clk = ~clk;

  ssp_frame_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .fs_n_in(fsn), .sdi_in(sdi),
    .sdo_out(sdo), .tx_word(tx_word), .wr_valid(wr_valid), .wr_word(wr_word),
    .test_reg(test_reg)
  );

  always @(negedge clk) if (wr_valid) begin
    pulses   = pulses + 1;
    got_word = wr_word;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [13:0] treg_next(input logic [13:0] cur,
                                            input logic [15:0] w);
    return (w[15:14] == 2'b01) ? w[13:0] : cur;
  endfunction

  task automatic run_frame(input logic [15:0] tx, input logic [15:0] rx,
                           input int nbits, input bit low_start);
    logic [15:0] seen = '0;
    int          p0 = pulses;
    tx_word = tx;
    sclk    = low_start ? 1'b0 : 1'b1;
    wait_cyc(HALF);
    fsn = 1'b0;
    wait_cyc(HALF);
    if (low_start) chk(sdo == tx[15], "R3 msb on frame edge", sdo, tx[15]);
    else           chk(sdo == 1'b0, "R4 no data before first fall", sdo, 0);
    for (int i = 0; i < nbits; i++) begin
      if (!(low_start && i == 0)) sclk = 1'b0;
      sdi = (i < 16) ? rx[15-i] : 1'($urandom);
      wait_cyc(HALF);
      if (i < 16) seen[15-i] = sdo;
      sclk = 1'b1;
      wait_cyc(HALF);
    end
    fsn = 1'b1;
    wait_cyc(HALF);
    chk(sdo == 1'b0, "R10 idle output", sdo, 0);
    if (nbits >= 16) begin
      chk(seen == tx, "R5 output bit order", seen, tx);
      chk(pulses - p0 == 1, nbits > 16 ? "R7 single strobe" : "R2 single strobe",
          pulses - p0, 1);
      chk(got_word == rx, "R2 received word", got_word, rx);
      model_treg = treg_next(model_treg, rx);
    end else begin
      chk(pulses == p0, "R6 partial word discarded", pulses - p0, 0);
    end
    chk(test_reg == model_treg, "R8 test register", test_reg, model_treg);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; sclk = 1'b1; fsn = 1'b1; sdi = 1'b0; tx_word = 16'h0;
    model_treg = 14'h0002;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(sdo == 1'b0 && wr_valid == 1'b0, "R1 outputs", {sdo, wr_valid}, 0);
    chk(test_reg == 14'h0002, "R1 test default", test_reg, 14'h0002);

    // Directed corners
    run_frame(16'hA5C3, 16'h1234, 16, 1'b0);   // R4 path
    run_frame(16'h5A3C, 16'h8123, 16, 1'b1);   // R3 path, R8 code 10 ignored
    run_frame(16'hFFFF, 16'h7FFF, 9, 1'b0);    // R6 cut short
    run_frame(16'h8001, 16'h7FFF, 16, 1'b0);   // R6 fresh word after cut
    run_frame(16'h0F0F, 16'hC000, 16, 1'b1);   // R8 code 11 ignored
    run_frame(16'h1357, 16'h4002, 16, 1'b0);   // R9 restore
    chk(test_reg == 14'h0002, "R9 restored default", test_reg, 14'h0002);
    run_frame(16'h2468, 16'h7ABC, 20, 1'b1);   // R7 extra clocks
    run_frame(16'h0000, 16'h4002, 20, 1'b0);   // R7 + R9

    // Random frames
    for (int k = 0; k < 30; k++) begin
      logic [15:0] t = 16'($urandom);
      logic [15:0] r = 16'($urandom);
      int nb;
      if ($urandom % 2) r[15:14] = 2'b01;
      nb = ($urandom % 5 == 0) ? int'(1 + $urandom % 15) : int'(16 + $urandom % 4);
      run_frame(t, r, nb, 1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule